// File: doc/BRIEF.md
# CPU Clock Performance-Level Controller

This block chooses the CPU clock source and divide code from one of four performance levels. Level 0 is the fastest (nominally 1200 MHz), then 600, 300 and 200 MHz for levels 1 to 3. A 32-bit configuration register holds two levels, so two registers describe all four. A simple write/read register port gives access to those registers, to a dynamic-mode enable bit, to a static fallback register and to the current-level register. The outputs are only selection codes: the source select, the divide code and a clock-select bit. The block does not generate a clock and does not regulate voltage.

Software asks for a new level by naming a divide code on a valid/ready request port. The block searches the levels from 0 to 3 and moves to the first level whose divide code matches. A jump to level 0 from level 2 or 3 goes through level 1 first. The block stays at level 1 for a programmable settle time and only then moves to level 0. Source changes use a separate strobe. A source change is accepted only while dynamic mode is off, and it writes the same source into all four level slots.

Back-pressure rules: `req_ready` is low for the whole of a stepped transition. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. The result comes back as a one-cycle pulse on `resp_valid` in the next cycle. That pulse has no ready signal and cannot be stalled. The source strobe is always taken, and it answers with a one-cycle pulse on `src_ok` or on `src_err`.

Top module: `dvfs_level_ctrl`

## Requirements
- R1: After reset the current level is 0, dynamic mode is off, `busy` is 0, `req_ready` is 1 and every register reads as 0.
- R2: Level slots are 16 bits wide. Level 0 is bits 31:16 of register 0x18 and level 1 is bits 15:0 of 0x18. Level 2 is bits 31:16 of 0x1C and level 3 is bits 15:0 of 0x1C. Inside a slot, the divide code is bits 15:13, the clock-select bit is bit 11 and the source is bits 10:9.
- R3: While dynamic mode is off, `act_src` comes from bits 1:0 of register 0x00 and `act_div` comes from bits 6:4 of register 0x00. `act_csel` is 0 in this mode.
- R4: Bit 31 of register 0x24 turns dynamic mode on. In dynamic mode the outputs come from the slot of the current level.
- R5: The current level is bits 1:0 of register 0x30. A bus write to 0x30 sets the level, except during a stepped transition.
- R6: When dynamic mode is off, a source strobe writes `src_sel` into the source field of all four slots and pulses `src_ok` one cycle later. When dynamic mode is on, the strobe pulses `src_err` and leaves the slots unchanged.
- R7: In dynamic mode, an accepted divide request moves the level to the lowest-numbered level whose divide code matches. `resp_valid` then pulses with `resp_ok`=1 one cycle after the request is taken.
- R8: A divide request that matches no level, or that arrives while dynamic mode is off, answers with `resp_ok`=0 and leaves the level unchanged.
- R9: A request that resolves to level 0 while the current level is 2 or 3 sets the level to 1 and raises `busy`. `busy` stays high for `settle_cycles`+1 cycles, and the level then becomes 0.
- R10: `req_ready` is low while `busy` is high, and no response is produced from a cycle in which `busy` was high.
- R11: `div_bad` is high when the active divide code is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read byte address |
| rd_data | output | 32 | Register read data (combinational) |
| settle_cycles | input | 24 | Settle time in cycles used by a stepped transition |
| src_valid | input | 1 | Source broadcast strobe |
| src_sel | input | 2 | Source code to broadcast |
| src_ok | output | 1 | Broadcast applied (pulse) |
| src_err | output | 1 | Broadcast refused because dynamic mode is on (pulse) |
| req_valid | input | 1 | Divide-code level request valid |
| req_ready | output | 1 | Level request can be taken |
| req_div | input | 3 | Requested divide code |
| resp_valid | output | 1 | Level request result valid (pulse) |
| resp_ok | output | 1 | Level request matched a level |
| cur_level | output | 2 | Current level |
| busy | output | 1 | Stepped transition in progress |
| act_src | output | 2 | Active clock source select |
| act_div | output | 3 | Active divide code |
| act_csel | output | 1 | Active clock-select bit |
| div_bad | output | 1 | Active divide code is invalid |

## Verification
Divide requests are sent from several start levels: a code held only by level 2, a code that no level holds, a code held by two levels, and a level-0 code sent from level 3 and from level 1. Together these separate search order, rejection, the stepped path and the direct path. Source strobes are sent with dynamic mode off and on, and the slot registers are read back after each one. This shows whether the broadcast reached all four slots and whether the lock held. The static fallback is checked before dynamic mode is turned on, and an out-of-range divide code is planted in the active slot to check `div_bad`.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam int NLVL = 4;
  localparam int LW = $clog2(NLVL);

  localparam logic [AW-1:0] A_STATIC = 6'h00;
  localparam logic [AW-1:0] A_CFG01  = 6'h18;
  localparam logic [AW-1:0] A_CFG23  = 6'h1C;
  localparam logic [AW-1:0] A_DYN    = 6'h24;
  localparam logic [AW-1:0] A_LOAD   = 6'h30;

  typedef struct packed {
    logic [2:0] div;
    logic       rsv12;
    logic       csel;
    logic [1:0] src;
    logic [8:0] rsv;
  } slot_t;

  function automatic slot_t slot_of(input logic [DW-1:0] c01,
                                    input logic [DW-1:0] c23,
                                    input logic [LW-1:0] idx);
    logic [DW-1:0] r;
    r = idx[1] ? c23 : c01;
    return idx[0] ? slot_t'(r[15:0]) : slot_t'(r[31:16]);
  endfunction
endpackage

// File: rtl/dvfs_regs.sv
module dvfs_regs
  import dvfs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          src_valid,
  input  logic [1:0]    src_sel,
  output logic [DW-1:0] cfg01,
  output logic [DW-1:0] cfg23,
  output logic          dyn_en,
  output logic [1:0]    static_src,
  output logic [2:0]    static_div,
  output logic          src_ok,
  output logic          src_err
);
  function automatic logic [DW-1:0] put_src(input logic [DW-1:0] r,
                                            input logic [1:0] s);
    logic [DW-1:0] v;
    v = r;
    v[10:9]  = s;
    v[26:25] = s;
    return v;
  endfunction

  logic do_bcast;
  assign do_bcast = src_valid && !dyn_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg01 <= '0; cfg23 <= '0; dyn_en <= 1'b0;
      static_src <= '0; static_div <= '0;
      src_ok <= 1'b0; src_err <= 1'b0;
    end else begin
      src_ok  <= do_bcast;
      src_err <= src_valid && dyn_en;
      if (wr_en && wr_addr == A_CFG01) cfg01 <= wr_data;
      else if (do_bcast)                cfg01 <= put_src(cfg01, src_sel);
      if (wr_en && wr_addr == A_CFG23) cfg23 <= wr_data;
      else if (do_bcast)                cfg23 <= put_src(cfg23, src_sel);
      if (wr_en && wr_addr == A_DYN) dyn_en <= wr_data[31];
      if (wr_en && wr_addr == A_STATIC) begin
        static_src <= wr_data[1:0];
        static_div <= wr_data[6:4];
      end
    end
  end

  AST_SRC_OK_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
    src_ok |-> !$past(dyn_en)); // R6
endmodule

// File: rtl/dvfs_level_seq.sv
module dvfs_level_seq
  import dvfs_pkg::*;
#(
  parameter int SETTLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dyn_en,
  input  logic [DW-1:0]       cfg01,
  input  logic [DW-1:0]       cfg23,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                req_valid,
  input  logic [2:0]          req_div,
  output logic                req_ready,
  input  logic                ld_wr,
  input  logic [LW-1:0]       ld_data,
  output logic [LW-1:0]       level,
  output logic                busy,
  output logic                resp_valid,
  output logic                resp_ok
);
  logic [NLVL-1:0] hit_vec;
  logic            hit;
  logic [LW-1:0]   hit_lvl;
  logic [SETTLE_W-1:0] cnt;

  for (genvar i = 0; i < NLVL; i++) begin : g_cmp
    slot_t s;
    assign s = slot_of(cfg01, cfg23, LW'(i));
    assign hit_vec[i] = (s.div == req_div);
  end

  always_comb begin
    hit = 1'b0;
    hit_lvl = '0;
    for (int i = NLVL - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit = 1'b1;
        hit_lvl = LW'(i);
      end
    end
  end

  assign req_ready = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level <= '0; busy <= 1'b0; cnt <= '0;
      resp_valid <= 1'b0; resp_ok <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      if (busy) begin
        if (cnt == '0) begin
          level <= '0;
          busy  <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (req_valid) begin
        resp_valid <= 1'b1;
        resp_ok    <= dyn_en && hit;
        if (dyn_en && hit) begin
          if (hit_lvl == '0 && level[1]) begin
            level <= LW'(1);
            busy  <= 1'b1;
            cnt   <= settle_cycles;
          end else begin
            level <= hit_lvl;
          end
        end
      end else if (ld_wr) begin
        level <= ld_data;
      end
    end
  end

  AST_BUSY_AT_L1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> level == LW'(1)); // R9
  AST_STEP_FROM_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(level) >= LW'(2)); // R9
  AST_STEP_ENDS_L0: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> level == '0); // R9
  AST_NO_RESP_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !$past(busy)); // R10
endmodule

// File: rtl/dvfs_out_sel.sv
module dvfs_out_sel
  import dvfs_pkg::*;
(
  input  logic          dyn_en,
  input  logic [LW-1:0] level,
  input  logic [DW-1:0] cfg01,
  input  logic [DW-1:0] cfg23,
  input  logic [1:0]    static_src,
  input  logic [2:0]    static_div,
  output logic [1:0]    act_src,
  output logic [2:0]    act_div,
  output logic          act_csel,
  output logic          div_bad
);
  slot_t cur;
  assign cur = slot_of(cfg01, cfg23, level);

  always_comb begin
    if (dyn_en) begin
      act_src  = cur.src;
      act_div  = cur.div;
      act_csel = cur.csel;
    end else begin
      act_src  = static_src;
      act_div  = static_div;
      act_csel = 1'b0;
    end
    div_bad = (act_div > 3'd6);
  end
endmodule

// File: rtl/dvfs_level_ctrl.sv
module dvfs_level_ctrl
  import dvfs_pkg::*;
#(
  parameter int SETTLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [DW-1:0]       rd_data,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                src_valid,
  input  logic [1:0]          src_sel,
  output logic                src_ok,
  output logic                src_err,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [2:0]          req_div,
  output logic                resp_valid,
  output logic                resp_ok,
  output logic [LW-1:0]       cur_level,
  output logic                busy,
  output logic [1:0]          act_src,
  output logic [2:0]          act_div,
  output logic                act_csel,
  output logic                div_bad
);
  logic [DW-1:0] cfg01, cfg23;
  logic          dyn_en;
  logic [1:0]    static_src;
  logic [2:0]    static_div;

  dvfs_regs u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .src_valid, .src_sel,
    .cfg01, .cfg23, .dyn_en, .static_src, .static_div, .src_ok, .src_err
  );

  dvfs_level_seq #(.SETTLE_W(SETTLE_W)) u_seq (
    .clk, .rst_n, .dyn_en, .cfg01, .cfg23, .settle_cycles,
    .req_valid, .req_div, .req_ready,
    .ld_wr(wr_en && wr_addr == A_LOAD), .ld_data(wr_data[LW-1:0]),
    .level(cur_level), .busy, .resp_valid, .resp_ok
  );

  dvfs_out_sel u_out (
    .dyn_en, .level(cur_level), .cfg01, .cfg23, .static_src, .static_div,
    .act_src, .act_div, .act_csel, .div_bad
  );

  always_comb begin
    case (rd_addr)
      A_STATIC: rd_data = {25'b0, static_div, 2'b0, static_src};
      A_CFG01:  rd_data = cfg01;
      A_CFG23:  rd_data = cfg23;
      A_DYN:    rd_data = {dyn_en, 31'b0};
      A_LOAD:   rd_data = {{(DW-LW){1'b0}}, cur_level};
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: tb/dvfs_level_ctrl_test.sv
module dvfs_level_ctrl_test;
  localparam time TCLK = 10ns;
  localparam int  SETTLE = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [23:0] settle_cycles = 24'(SETTLE);
  logic src_valid = 1'b0; logic [1:0] src_sel = '0;
  logic src_ok, src_err;
  logic req_valid = 1'b0, req_ready; logic [2:0] req_div = '0;
  logic resp_valid, resp_ok, busy, act_csel, div_bad;
  logic [1:0] cur_level, act_src; logic [2:0] act_div;

  int checks = 0, fails = 0;
  bit exp_q[$];

  dvfs_level_ctrl uut (.*);

  always #(TCLK/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a; #1; d = rd_data;
  endtask

  task automatic level_req(input logic [2:0] code, input bit exp_ok);
    @(negedge clk);
    exp_q.push_back(exp_ok);
    req_valid = 1'b1; req_div = code;
    @(negedge clk); req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_q.size() == 0) chk("R7 unexpected response", 1, 0);
      else chk("R7/R8 response ok bit", resp_ok, exp_q.pop_front());
    end
  end

  function automatic logic [31:0] with_src(input logic [31:0] r, input logic [1:0] s);
    logic [31:0] v = r;
    v[10:9] = s; v[26:25] = s;
    return v;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 level", cur_level, 0);
    chk("R1 busy", busy, 0);
    chk("R1 ready", req_ready, 1);
    rd(6'h18, d); chk("R1 cfg01", d, 0);
    rd(6'h24, d); chk("R1 dyn", d, 0);

    // R3 static fallback
    wr(6'h00, 32'h53);
    chk("R3 src", act_src, 3); chk("R3 div", act_div, 5); chk("R3 csel", act_csel, 0);

    // R6 broadcast with dynamic mode off
    wr(6'h18, 32'h2C00_4200);
    wr(6'h1C, 32'h8E00_C000);
    @(negedge clk); src_valid = 1'b1; src_sel = 2'd1;
    @(negedge clk); src_valid = 1'b0;
    chk("R6 src_ok", src_ok, 1);
    rd(6'h18, d); chk("R6 cfg01 bcast", d, with_src(32'h2C00_4200, 1));
    rd(6'h1C, d); chk("R6 cfg23 bcast", d, with_src(32'h8E00_C000, 1));
    wr(6'h18, 32'h2C00_4200);
    wr(6'h1C, 32'h8E00_C000);

    // R8 request while dynamic mode off
    level_req(3'd4, 0);
    @(negedge clk);
    chk("R8 level kept (static)", cur_level, 0);

    // R4/R2 dynamic mode on, level 0 slot
    wr(6'h24, 32'h8000_0000);
    chk("R4 src L0", act_src, 2); chk("R2 div L0", act_div, 1); chk("R2 csel L0", act_csel, 1);

    // R6 broadcast refused
    @(negedge clk); src_valid = 1'b1; src_sel = 2'd3;
    @(negedge clk); src_valid = 1'b0;
    chk("R6 src_err", src_err, 1);
    rd(6'h18, d); chk("R6 cfg01 locked", d, 32'h2C00_4200);

    // R7 search to level 2
    level_req(3'd4, 1);
    chk("R7 level 2", cur_level, 2);
    chk("R2 L2 fields", {act_src, act_div, act_csel}, {2'd3, 3'd4, 1'b1});
    rd(6'h30, d); chk("R5 load readback", d, 2);

    // R8 no match
    level_req(3'd5, 0);
    @(negedge clk);
    chk("R8 level kept", cur_level, 2);

    // R5 direct load write, R2 level 3 slot
    wr(6'h30, 32'h3);
    chk("R5 level 3", cur_level, 3);
    chk("R2 L3 fields", {act_src, act_div, act_csel}, {2'd0, 3'd6, 1'b0});

    // R9/R10 stepped transition from level 3
    level_req(3'd1, 1);
    chk("R9 via L1", cur_level, 1);
    chk("R10 ready low", req_ready, 0);
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    chk("R9 busy length", n, SETTLE + 1);
    chk("R9 final L0", cur_level, 0);

    // R7 first match wins: level 1 and level 3 both hold divide code 2
    wr(6'h1C, 32'h8E00_4000);
    level_req(3'd2, 1);
    chk("R7 first match L1", cur_level, 1);

    // R11 invalid divide code in active slot
    wr(6'h18, 32'h2C00_E200);
    chk("R11 div_bad", div_bad, 1);
    chk("R11 act_div", act_div, 7);

    // R9 direct to L0 from L1: no stepping
    level_req(3'd1, 1);
    chk("R9 direct L0", cur_level, 0);
    chk("R9 not busy", busy, 0);
    chk("R11 div_bad clear", div_bad, 0);

    repeat (3) @(negedge clk);
    chk("R7 queue drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule